// File: doc/BRIEF.md
# Stereo Ramped Volume and Mute Stage

This block applies a per-channel linear gain to a stereo stream of signed 24-bit samples. Software stores a 14-bit unsigned gain word for each channel; all ones means unity gain and zero means silence. A stored word does not reach the audio path straight away. It becomes the channel's target only at the next transition, rising or falling, of the frame clock. The applied gain then moves toward that target so that a large volume step produces no audible click.

The applied gain is split into two parts. The upper 10 bits (the coarse part) move by one count on each valid sample until they match the target. The lower 4 bits (the fine part) follow the target on the next clock. Muting comes from an external pin or from a soft control bit, either one being enough. While muted, the target is treated as zero, so the gain ramps down to silence. Releasing mute ramps the gain back to the target held for that channel. Each sample is multiplied by the gain applied before that sample's ramp step, divided by 2^14 with truncation toward zero, and clipped to 24 bits.

Top module: `stereo_ramp_gain`

## Requirements
- R1: After reset both applied gains read 0x3FFF, both outputs read 0 and `out_valid` is low.
- R2: A cycle with `wr_en` high stores `wr_gain` for the channel given by `wr_chan` (0 = left, 1 = right). The stored value becomes that channel's target only on a clock in which `frame_clk` differs from its value at the previous clock (either edge). Until then the applied gain is unaffected.
- R3: The fine part of the applied gain (bits 3:0) equals bits 3:0 of the effective target one clock after the effective target changes.
- R4: On each clock with `sample_valid` high, the coarse part of the applied gain (bits 13:4) moves by exactly one toward bits 13:4 of the effective target. It is unchanged on clocks without `sample_valid` and once it equals the target.
- R5: The channel is muted when `mute_pin` or `soft_mute` is high. While muted, the effective target is 0, so the fine part reads 0 and the coarse part ramps down to 0.
- R6: When mute is released, both channels ramp back to the targets they held, and no write is needed.
- R7: Each channel keeps its own stored gain, target and ramp. A write or ramp on one channel never alters the other channel.
- R8: On a clock with `sample_valid` high, each output is registered as input × gain / 2^14, truncated toward zero and clipped to [-2^23, 2^23-1]. The gain used is the one applied before that clock's step. `out_valid` is high for exactly the following cycle, and the outputs hold between valid samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Gain-word write strobe |
| wr_chan | input | 1 | Channel written: 0 left, 1 right |
| wr_gain | input | 14 | Unsigned linear gain word |
| frame_clk | input | 1 | Frame clock; either transition loads the stored words as targets |
| mute_pin | input | 1 | Hardware mute request |
| soft_mute | input | 1 | Software mute bit |
| sample_valid | input | 1 | One new stereo sample this cycle |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| out_valid | output | 1 | Outputs updated in the previous clock |
| gain_left | output | 14 | Left applied gain |
| gain_right | output | 14 | Right applied gain |

## Verification
The assertions check the following on every cycle. The coarse gain never moves by more than one count, and it stays still when no sample arrives. The fine gain drops to zero one clock into a mute. The gain never rises while muted. `out_valid` follows `sample_valid` one cycle later, and no output exceeds its input in magnitude. The bench scenarios cover what holds only across many cycles: the exact scaled values, the delay from a write to the next frame edge, complete ramps to each target, the ramp back after mute is released, and the independence of the two channels.

// File: rtl/ramp_gain_pkg.sv
package ramp_gain_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/rg_target_regs.sv
module rg_target_regs #(
  parameter int GAIN_W = 14,
  parameter int NCH    = 2,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_chan,
  input  logic [GAIN_W-1:0] wr_gain,
  input  logic              frame_clk,
  output logic [GAIN_W-1:0] target [NCH]
);

  logic              frame_q;
  logic              frame_edge;
  logic [GAIN_W-1:0] stored_q [NCH];
  logic [GAIN_W-1:0] stored_d [NCH];
  logic [GAIN_W-1:0] tgt_q    [NCH];
  logic [GAIN_W-1:0] tgt_d    [NCH];

  assign frame_edge = frame_clk ^ frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b0;
    else        frame_q <= frame_clk;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [SEL_W-1:0] IDX = SEL_W'(c);

    always_comb begin
      stored_d[c] = stored_q[c];
      if (wr_en && (wr_chan == IDX)) stored_d[c] = wr_gain;
    end

    always_comb begin
      tgt_d[c] = tgt_q[c];
      if (frame_edge) tgt_d[c] = stored_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stored_q[c] <= '1;
        tgt_q[c]    <= '1;
      end else begin
        stored_q[c] <= stored_d[c];
        tgt_q[c]    <= tgt_d[c];
      end
    end

    assign target[c] = tgt_q[c];
  end

endmodule

// File: rtl/rg_ramp.sv
module rg_ramp #(
  parameter int GAIN_W = 14,
  parameter int FINE_W = 4,
  localparam int COARSE_W = GAIN_W - FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAIN_W-1:0] target,
  input  logic              muted,
  input  logic              step_en,
  output logic [GAIN_W-1:0] gain
);

  logic [GAIN_W-1:0]   eff_tgt;
  logic [COARSE_W-1:0] eff_coarse;
  logic [FINE_W-1:0]   eff_fine;
  logic [COARSE_W-1:0] coarse_q, coarse_d;
  logic [FINE_W-1:0]   fine_q, fine_d;

  assign eff_tgt    = muted ? '0 : target;
  assign eff_coarse = eff_tgt[GAIN_W-1:FINE_W];
  assign eff_fine   = eff_tgt[FINE_W-1:0];

  always_comb begin
    coarse_d = coarse_q;
    if (step_en) begin
      if (coarse_q < eff_coarse)      coarse_d = coarse_q + 1'b1;
      else if (coarse_q > eff_coarse) coarse_d = coarse_q - 1'b1;
    end
  end

  always_comb begin
    fine_d = eff_fine;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '1;
      fine_q   <= '1;
    end else begin
      coarse_q <= coarse_d;
      fine_q   <= fine_d;
    end
  end

  assign gain = {coarse_q, fine_q};

endmodule

// File: rtl/rg_scaler.sv
module rg_scaler #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 14,
  localparam int PW = DATA_W + GAIN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] dout
);

  localparam logic signed [PW-1:0] BIAS  = PW'((64'sd1 <<< GAIN_W) - 64'sd1);
  localparam logic signed [PW-1:0] MAX_V = PW'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] MIN_V = -PW'(64'sd1 <<< (DATA_W - 1));

  logic signed [PW-1:0]     prod;
  logic signed [PW-1:0]     biased;
  logic signed [PW-1:0]     shifted;
  logic        [DATA_W-1:0] clipped;
  logic        [DATA_W-1:0] dout_q, dout_d;

  assign prod    = PW'($signed(din)) * $signed({{(PW-GAIN_W){1'b0}}, gain});
  assign biased  = prod + (prod[PW-1] ? BIAS : '0);
  assign shifted = biased >>> GAIN_W;

  always_comb begin
    if (shifted > MAX_V)      clipped = MAX_V[DATA_W-1:0];
    else if (shifted < MIN_V) clipped = MIN_V[DATA_W-1:0];
    else                      clipped = shifted[DATA_W-1:0];
  end

  always_comb begin
    dout_d = dout_q;
    if (en) dout_d = clipped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

endmodule

// File: rtl/stereo_ramp_gain.sv
module stereo_ramp_gain #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 14,
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_chan,
  input  logic [GAIN_W-1:0] wr_gain,
  input  logic              frame_clk,
  input  logic              mute_pin,
  input  logic              soft_mute,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              out_valid,
  output logic [GAIN_W-1:0] gain_left,
  output logic [GAIN_W-1:0] gain_right
);
  import ramp_gain_pkg::*;

  logic [GAIN_W-1:0] target [NUM_CH];
  logic [GAIN_W-1:0] gain   [NUM_CH];
  logic [DATA_W-1:0] din    [NUM_CH];
  logic [DATA_W-1:0] dout   [NUM_CH];
  logic              muted;
  logic              valid_q, valid_d;

  assign muted = mute_pin | soft_mute;

  assign din[int'(CH_LEFT)]  = in_left;
  assign din[int'(CH_RIGHT)] = in_right;

  rg_target_regs #(
    .GAIN_W (GAIN_W),
    .NCH    (NUM_CH)
  ) u_targets (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_chan   (wr_chan),
    .wr_gain   (wr_gain),
    .frame_clk (frame_clk),
    .target    (target)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    rg_ramp #(
      .GAIN_W (GAIN_W),
      .FINE_W (FINE_W)
    ) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .target  (target[c]),
      .muted   (muted),
      .step_en (sample_valid),
      .gain    (gain[c])
    );

    rg_scaler #(
      .DATA_W (DATA_W),
      .GAIN_W (GAIN_W)
    ) u_scale (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sample_valid),
      .din   (din[c]),
      .gain  (gain[c]),
      .dout  (dout[c])
    );
  end

  always_comb begin
    valid_d = sample_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign out_valid  = valid_q;
  assign out_left   = dout[int'(CH_LEFT)];
  assign out_right  = dout[int'(CH_RIGHT)];
  assign gain_left  = gain[int'(CH_LEFT)];
  assign gain_right = gain[int'(CH_RIGHT)];

endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 14,
  parameter int FINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mute_pin,
  input logic              soft_mute,
  input logic              sample_valid,
  input logic [DATA_W-1:0] in_left,
  input logic [DATA_W-1:0] in_right,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic              out_valid,
  input logic [GAIN_W-1:0] gain_left,
  input logic [GAIN_W-1:0] gain_right
);

  function automatic logic [DATA_W:0] mag(input logic [DATA_W-1:0] v);
    logic [DATA_W:0] e;
    e = {v[DATA_W-1], v};
    return e[DATA_W] ? (~e + 1'b1) : e;
  endfunction

  assert_hold_no_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> ($stable(gain_left[GAIN_W-1:FINE_W]) && $stable(gain_right[GAIN_W-1:FINE_W])));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=>
      ((gain_left[GAIN_W-1:FINE_W] == $past(gain_left[GAIN_W-1:FINE_W])) ||
       (gain_left[GAIN_W-1:FINE_W] == $past(gain_left[GAIN_W-1:FINE_W]) + 1'b1) ||
       (gain_left[GAIN_W-1:FINE_W] == $past(gain_left[GAIN_W-1:FINE_W]) - 1'b1)) &&
      ((gain_right[GAIN_W-1:FINE_W] == $past(gain_right[GAIN_W-1:FINE_W])) ||
       (gain_right[GAIN_W-1:FINE_W] == $past(gain_right[GAIN_W-1:FINE_W]) + 1'b1) ||
       (gain_right[GAIN_W-1:FINE_W] == $past(gain_right[GAIN_W-1:FINE_W]) - 1'b1)));

  assert_mute_fine_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_pin || soft_mute) |=> (gain_left[FINE_W-1:0] == '0 && gain_right[FINE_W-1:0] == '0));

  assert_mute_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_pin || soft_mute) |=> (gain_left <= $past(gain_left) && gain_right <= $past(gain_right)));

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> out_valid);

  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !out_valid);

  assert_no_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> (mag(out_left) <= mag($past(in_left)) && mag(out_right) <= mag($past(in_right))));

endmodule

bind stereo_ramp_gain rg_checker #(
  .DATA_W (DATA_W),
  .GAIN_W (GAIN_W),
  .FINE_W (FINE_W)
) u_rg_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .mute_pin     (mute_pin),
  .soft_mute    (soft_mute),
  .sample_valid (sample_valid),
  .in_left      (in_left),
  .in_right     (in_right),
  .out_left     (out_left),
  .out_right    (out_right),
  .out_valid    (out_valid),
  .gain_left    (gain_left),
  .gain_right   (gain_right)
);

// File: tb/tb_stereo_ramp_gain.sv
module tb_stereo_ramp_gain;
  localparam int PERIOD = 10;

  logic        clk, rst_n;
  logic        wr_en, wr_chan;
  logic [13:0] wr_gain;
  logic        frame_clk, mute_pin, soft_mute, sample_valid;
  logic [23:0] in_left, in_right, out_left, out_right;
  logic        out_valid;
  logic [13:0] gain_left, gain_right;

  stereo_ramp_gain dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_gain(wr_gain),
    .frame_clk(frame_clk), .mute_pin(mute_pin), .soft_mute(soft_mute),
    .sample_valid(sample_valid), .in_left(in_left), .in_right(in_right),
    .out_left(out_left), .out_right(out_right), .out_valid(out_valid),
    .gain_left(gain_left), .gain_right(gain_right)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // bench model, built from the requirements
  int m_reg[2], m_tgt[2], m_hi[2], m_lo[2], m_out[2];
  bit m_ov, m_fcq;
  bit drv_fc, drv_mp, drv_sm;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int scale(input int x, input int g);
    longint p, q;
    p = longint'(x) * longint'(g);
    q = p / 16384;
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return int'(q);
  endfunction

  task automatic cyc(input bit wr, input bit ch, input int val, input bit sv, input int il, input int ir);
    int  ins[2];
    bit  muted;
    int  eff;
    @(negedge clk);
    wr_en = wr; wr_chan = ch; wr_gain = val[13:0];
    frame_clk = drv_fc; mute_pin = drv_mp; soft_mute = drv_sm;
    sample_valid = sv; in_left = il[23:0]; in_right = ir[23:0];
    ins[0] = il; ins[1] = ir;
    muted = drv_mp | drv_sm;
    for (int c = 0; c < 2; c++) begin
      eff = muted ? 0 : m_tgt[c];
      if (sv) begin
        m_out[c] = scale(ins[c], m_hi[c] * 16 + m_lo[c]);
        if (m_hi[c] < (eff >> 4)) m_hi[c]++;
        else if (m_hi[c] > (eff >> 4)) m_hi[c]--;
      end
      m_lo[c] = eff & 15;
      if (drv_fc != m_fcq) m_tgt[c] = m_reg[c];
      if (wr && (ch == c[0])) m_reg[c] = val;
    end
    m_fcq = drv_fc;
    m_ov = sv;
    @(posedge clk);
    #1;
    check(cur_req, "gain_left", gain_left, m_hi[0] * 16 + m_lo[0]);
    check(cur_req, "gain_right", gain_right, m_hi[1] * 16 + m_lo[1]);
    check("R8", "out_valid", out_valid, m_ov);
    check("R8", "out_left", $signed(out_left), m_out[0]);
    check("R8", "out_right", $signed(out_right), m_out[1]);
  endtask

  function automatic int pat(input int k, input int salt);
    longint v;
    v = (longint'(k) * 1234567 + longint'(salt) * 7654321) % 16777216;
    return int'(v) - 8388608;
  endfunction

  task automatic samples(input int n, input int salt);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 1, pat(k, salt), pat(k + 17, salt + 3));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic flip_frame();
    drv_fc = ~drv_fc;
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int corners[8];
    rst_n = 0; wr_en = 0; wr_chan = 0; wr_gain = 0; frame_clk = 0;
    mute_pin = 0; soft_mute = 0; sample_valid = 0; in_left = 0; in_right = 0;
    drv_fc = 0; drv_mp = 0; drv_sm = 0; m_fcq = 0; m_ov = 0;
    for (int c = 0; c < 2; c++) begin
      m_reg[c] = 16383; m_tgt[c] = 16383; m_hi[c] = 1023; m_lo[c] = 15; m_out[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "gain_left", gain_left, 16383);
    check("R1", "gain_right", gain_right, 16383);
    check("R1", "out_left", out_left, 0);
    check("R1", "out_valid", out_valid, 0);
    @(negedge clk);
    rst_n = 1;

    // R8: boundary values at unity-minus-one-LSB gain
    cur_req = "R8";
    corners = '{8388607, -8388608, -1, 1, 0, 16384, -16385, 4660};
    for (int k = 0; k < 8; k++) cyc(0, 0, 0, 1, corners[k], corners[7 - k]);
    idle(2);
    samples(40, 1);

    // R2: writes have no effect before a frame edge
    cur_req = "R2";
    cyc(1, 0, 5, 0, 0, 0);
    cyc(1, 1, 14'h2A37, 1, 1000, -1000);
    samples(30, 2);
    // R3 R4 R7: rising frame edge loads both targets, ramps run per channel
    cur_req = "R3";
    flip_frame();
    idle(1);
    cur_req = "R4";
    idle(3);
    samples(1030, 3);
    check("R7", "left at target", gain_left, 5);
    check("R7", "right at target", gain_right, 14'h2A37);

    // R2: falling frame edge also loads; R7: only right changes
    cur_req = "R2";
    cyc(1, 1, 14'h0123, 0, 0, 0);
    flip_frame();
    cur_req = "R7";
    samples(700, 4);
    check("R7", "right reached", gain_right, 14'h0123);
    check("R7", "left untouched", gain_left, 5);

    // R5: hardware pin mute ramps to zero
    cur_req = "R5";
    cyc(1, 0, 16383, 0, 0, 0);
    flip_frame();
    samples(20, 5);
    drv_mp = 1;
    samples(1030, 6);
    check("R5", "left muted", gain_left, 0);
    check("R5", "right muted", gain_right, 0);
    // R6: release returns to held targets
    cur_req = "R6";
    drv_mp = 0;
    samples(1030, 7);
    check("R6", "left restored", gain_left, 16383);
    check("R6", "right restored", gain_right, 14'h0123);

    // R5: soft mute, including a write and frame edge while muted
    cur_req = "R5";
    drv_sm = 1;
    samples(50, 8);
    cyc(1, 1, 14'h3FF0, 0, 0, 0);
    flip_frame();
    samples(1000, 9);
    cur_req = "R6";
    drv_sm = 0;
    samples(1030, 10);
    check("R6", "right new target", gain_right, 14'h3FF0);
    idle(3);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule